// File: doc/BRIEF.md
# SATA Port Engine Start/Stop Controller

This block owns the command register of one host port and the two engines that register governs: the command-list fetch engine and the received-FIS engine. Software writes the command register through a simple write port. The block merges the write with the read-only running bits and discards the interface-communication-control field. It then runs an engine check, which is driven by a mismatch between the two bits of each pair. When a start bit is set and its running bit is clear, the block validates that engine's base address. A valid address sets the running bit. An invalid one clears the start bit and pulses an error. When a start bit is clear and its running bit is set, the block stops the engine.

A second command path restores a saved register image. The block rejects the image if a running bit is set while its start bit is clear. Otherwise it clears both running bits and reruns the start check. The block also keeps the shadow task-file bytes and status, which a port reset loads according to the drive type. After receive-running first comes on, the block offers the initial device-to-host register FIS on a valid/ready stream. When that stream handshake completes, the block sets the D2H interrupt status bit and copies the shadow bytes into the signature register.

The FIS stream follows these rules. `fis_valid` stays high with a stable `fis_data` until `fis_ready` is seen high at a clock edge. A transfer happens on the edge where both are high. There is one exception to the hold rule: the request is withdrawn, and `fis_valid` drops without a transfer, if receive-enable or receive-running is cleared. A port reset also drops an accepted state and re-arms the request.

Top module: `sata_port_engine_ctl`

## Requirements
- R1: A command write keeps bits 15 and 14 (list-running, receive-running) at their stored value. It never stores bits 31:28 (interface control), which always read as zero. Every other bit is taken from the write data, except where the engine check in R2 to R5 modifies it.
- R2: A write that leaves bit 0 (list-start) set while list-running is clear sets list-running in the cycle after the write, provided the list base address is valid.
- R3: If the list base address is invalid in the case of R2, bits 0 and 15 both end clear, and `start_err[0]` pulses for one cycle.
- R4: With list-start clear and list-running set, the list engine stops and bit 15 clears.
- R5: Bit 4 (receive-enable) and bit 14 (receive-running) follow the rules of R2 to R4 using the receive base address, with `start_err[1]` as the error pulse.
- R6: A write that leaves an engine's start bit and running bit both clear pulses that engine's `stop_noop` bit, where bit 0 is list and bit 1 is receive. The write changes nothing else: it sets no running bit and raises no error.
- R7: A base address is {hi, lo}, 64 bits wide. It is valid when it is nonzero and aligned. The list base must sit on a 1024-byte boundary and the receive base on a 256-byte boundary.
- R8: While receive-enable and receive-running are set and the initial FIS has not yet been sent, `fis_valid` is high. `fis_data` is {status[7:0], shadow[31:0]}. The request holds while `fis_ready` is low, and the FIS counts as sent only when a handshake completes.
- R9: `fis_valid` is low whenever receive-enable or receive-running is clear. Clearing either one withdraws a pending request without setting `d2h_irq` and without changing the signature.
- R10: A completed handshake sets `d2h_irq` and loads the signature register with the shadow bytes {hcyl, lcyl, sector, nsector}, with hcyl in bits 31:24. The request is not raised again until a port reset.
- R11: Reset and `port_reset` load the shadow bytes with 32'hEB140101 when `drive_is_cd`=1, or with 32'h00000101 when it is 0. They load status with 8'h70 for CD-ROM or 8'h30 for disk, built from seek 8'h10, write-fault 8'h20 and ready 8'h40. They also clear `d2h_irq` and the sent flag.
- R12: A restore whose image has bit 15 set with bit 0 clear, or bit 14 set with bit 4 clear, pulses `restore_err` and leaves the command register unchanged.
- R13: An accepted restore drops bits 31:28 and both running bits from the image. It then runs the start check of R2 to R5 on the result, including `start_err` on a bad address.
- R14: `rd_data` shows the command register for `rd_sel`=0, the signature for 1, {24'b0, status} for 2, and the shadow bytes for 3. Reset clears the command and signature registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_reset | input | 1 | Port reset pulse: reloads shadow/status, clears sent flag and interrupt |
| drive_is_cd | input | 1 | Drive type: 1 = CD-ROM, 0 = disk |
| reg_we | input | 1 | Command register write strobe |
| reg_wdata | input | 32 | Command register write data |
| rd_sel | input | 2 | Read select |
| rd_data | output | 32 | Read data |
| restore_en | input | 1 | Restore-state strobe; takes priority over reg_we |
| restore_img | input | 32 | Saved command register image |
| list_base_hi | input | 32 | Command-list base, upper half |
| list_base_lo | input | 32 | Command-list base, lower half |
| rx_base_hi | input | 32 | FIS receive base, upper half |
| rx_base_lo | input | 32 | FIS receive base, lower half |
| start_err | output | 2 | Start-failure pulse per engine (0 list, 1 receive) |
| stop_noop | output | 2 | Already-stopped pulse per engine |
| restore_err | output | 1 | Inconsistent restore image pulse |
| fis_valid | output | 1 | Initial D2H FIS request |
| fis_ready | input | 1 | FIS sink accepts |
| fis_data | output | 40 | {status, shadow bytes} |
| d2h_irq | output | 1 | D2H register FIS interrupt status |

## Verification
A wrong merge or engine decision shows up in the command register read-back one cycle after the write, together with the error or no-op pulse of that same cycle. Because a stale running bit also gates the FIS request, the same fault shows on `fis_valid` immediately. A wrongly kept or cleared sent flag shows up later. It appears after a receive-engine restart or a port reset, as a request that fails to reappear or one that reappears once too often. A wrong shadow load becomes visible in `fis_data` and in the signature after the first accepted handshake.

// File: rtl/spe_pkg.sv
package spe_pkg;
  localparam int CMD_W   = 32;
  localparam int LST_BIT = 0;
  localparam int RXE_BIT = 4;
  localparam int RXR_BIT = 14;
  localparam int LSR_BIT = 15;
  localparam int ICC_LSB = 28;
  localparam int ICC_W   = 4;
  localparam int N_ENG   = 2;

  localparam logic [CMD_W-1:0] RUN_MASK = (CMD_W'(1) << RXR_BIT) | (CMD_W'(1) << LSR_BIT);
  localparam logic [CMD_W-1:0] ICC_MASK = ((CMD_W'(1) << ICC_W) - CMD_W'(1)) << ICC_LSB;
  localparam logic [CMD_W-1:0] STR_MASK = (CMD_W'(1) << LST_BIT) | (CMD_W'(1) << RXE_BIT);

  localparam logic [31:0] SIG_CDROM = 32'hEB14_0101;
  localparam logic [31:0] SIG_DISK  = 32'h0000_0101;
  localparam logic [7:0]  ST_SEEK   = 8'h10;
  localparam logic [7:0]  ST_WFAULT = 8'h20;
  localparam logic [7:0]  ST_READY  = 8'h40;

  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_SIG    = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_SHADOW = 2'd3
  } rd_sel_e;

  function automatic int start_bit(input int eng);
    return (eng == 0) ? LST_BIT : RXE_BIT;
  endfunction

  function automatic int run_bit(input int eng);
    return (eng == 0) ? LSR_BIT : RXR_BIT;
  endfunction
endpackage

// File: rtl/spe_addr_check.sv
module spe_addr_check #(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 10
) (
  input  logic [ADDR_W-1:0] base,
  output logic              ok
);
  localparam logic [ALIGN_BITS-1:0] ZERO_LOW = '0;

  always_comb begin
    ok = (base != '0) && (base[ALIGN_BITS-1:0] == ZERO_LOW);
  end
endmodule

// File: rtl/spe_engine.sv
module spe_engine (
  input  logic start_in,
  input  logic run_in,
  input  logic addr_ok,
  output logic start_out,
  output logic run_out,
  output logic fail,
  output logic idle
);
  always_comb begin
    start_out = start_in;
    run_out   = run_in;
    fail      = 1'b0;
    idle      = !start_in && !run_in;
    if (start_in && !run_in) begin
      if (addr_ok) begin
        run_out = 1'b1;
      end else begin
        start_out = 1'b0;
        run_out   = 1'b0;
        fail      = 1'b1;
      end
    end else if (!start_in && run_in) begin
      run_out = 1'b0;
    end
  end
endmodule

// File: rtl/spe_cmd_reg.sv
module spe_cmd_reg
  import spe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             restore_en,
  input  logic [CMD_W-1:0] restore_img,
  input  logic [N_ENG-1:0] addr_ok,
  output logic [CMD_W-1:0] cmd_q,
  output logic [N_ENG-1:0] start_err,
  output logic [N_ENG-1:0] stop_noop,
  output logic             restore_err
);
  localparam logic [CMD_W-1:0] PLAIN_MASK = ~(RUN_MASK | ICC_MASK | STR_MASK);

  logic [CMD_W-1:0] merged_wr;
  logic [CMD_W-1:0] restore_clean;
  logic [CMD_W-1:0] pre;
  logic [CMD_W-1:0] post;
  logic             img_bad;
  logic             wr_path;
  logic             do_check;
  logic [N_ENG-1:0] s_new;
  logic [N_ENG-1:0] r_new;
  logic [N_ENG-1:0] fail;
  logic [N_ENG-1:0] idle;

  always_comb begin
    merged_wr     = (cmd_q & RUN_MASK) | (wr_data & ~(RUN_MASK | ICC_MASK));
    restore_clean = restore_img & ~(RUN_MASK | ICC_MASK);
    img_bad       = (!restore_img[LST_BIT] && restore_img[LSR_BIT]) ||
                    (!restore_img[RXE_BIT] && restore_img[RXR_BIT]);
    wr_path       = wr_en && !restore_en;
    do_check      = wr_path || (restore_en && !img_bad);
    pre           = restore_en ? restore_clean : merged_wr;
  end

  for (genvar i = 0; i < N_ENG; i++) begin : g_eng
    localparam int SB = start_bit(i);
    localparam int RB = run_bit(i);
    spe_engine u_eng (
      .start_in (pre[SB]),
      .run_in   (pre[RB]),
      .addr_ok  (addr_ok[i]),
      .start_out(s_new[i]),
      .run_out  (r_new[i]),
      .fail     (fail[i]),
      .idle     (idle[i])
    );
  end

  always_comb begin
    post          = pre;
    post[LST_BIT] = s_new[0];
    post[LSR_BIT] = r_new[0];
    post[RXE_BIT] = s_new[1];
    post[RXR_BIT] = r_new[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      start_err   <= '0;
      stop_noop   <= '0;
      restore_err <= 1'b0;
    end else begin
      if (do_check) cmd_q <= post;
      start_err   <= do_check ? fail : '0;
      stop_noop   <= wr_path ? idle : '0;
      restore_err <= restore_en && img_bad;
    end
  end

  a_r1_plain_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !restore_en |=> ((cmd_q & PLAIN_MASK) == ($past(wr_data) & PLAIN_MASK)));

  a_r2_list_starts: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !restore_en && wr_data[LST_BIT] && !cmd_q[LSR_BIT] && addr_ok[0]
    |=> cmd_q[LSR_BIT]);

  a_r3_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_err[0] |-> !cmd_q[LST_BIT] && !cmd_q[LSR_BIT]);

  a_r4_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !restore_en && !wr_data[LST_BIT] |=> !cmd_q[LSR_BIT]);

  a_r5_rx_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_err[1] |-> !cmd_q[RXE_BIT] && !cmd_q[RXR_BIT]);

  a_r6_noop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stop_noop[0] |-> !cmd_q[LSR_BIT] && !start_err[0]);

  a_r12_restore_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    restore_err |-> $stable(cmd_q));
endmodule

// File: rtl/spe_init_fis.sv
module spe_init_fis
  import spe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_reset,
  input  logic        drive_is_cd,
  input  logic        rx_enable,
  input  logic        rx_running,
  input  logic        fis_ready,
  output logic        fis_valid,
  output logic [39:0] fis_data,
  output logic [31:0] sig_q,
  output logic [7:0]  status_q,
  output logic [31:0] shadow_q,
  output logic        d2h_irq
);
  logic sent_q;
  logic accept;

  always_comb begin
    fis_valid = rx_enable && rx_running && !sent_q;
    fis_data  = {status_q, shadow_q};
    accept    = fis_valid && fis_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || port_reset) begin
      shadow_q <= drive_is_cd ? SIG_CDROM : SIG_DISK;
      status_q <= drive_is_cd ? (ST_SEEK | ST_WFAULT | ST_READY) : (ST_SEEK | ST_WFAULT);
      sent_q   <= 1'b0;
      d2h_irq  <= 1'b0;
      if (!rst_n) sig_q <= '0;
    end else if (accept) begin
      sent_q  <= 1'b1;
      d2h_irq <= 1'b1;
      sig_q   <= shadow_q;
    end
  end

  a_r8_request_holds: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid && !fis_ready && !port_reset |=> fis_valid || !rx_enable || !rx_running);

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d2h_irq) |-> $past(fis_valid && fis_ready));

  a_r10_sig_load: assert property (@(posedge clk) disable iff (!rst_n)
    fis_valid && fis_ready && !port_reset |=> sig_q == $past(shadow_q));
endmodule

// File: rtl/sata_port_engine_ctl.sv
module sata_port_engine_ctl
  import spe_pkg::*;
#(
  parameter int ADDR_W          = 64,
  parameter int LIST_ALIGN_BITS = 10,
  parameter int RX_ALIGN_BITS   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                port_reset,
  input  logic                drive_is_cd,
  input  logic                reg_we,
  input  logic [31:0]         reg_wdata,
  input  logic [1:0]          rd_sel,
  output logic [31:0]         rd_data,
  input  logic                restore_en,
  input  logic [31:0]         restore_img,
  input  logic [ADDR_W/2-1:0] list_base_hi,
  input  logic [ADDR_W/2-1:0] list_base_lo,
  input  logic [ADDR_W/2-1:0] rx_base_hi,
  input  logic [ADDR_W/2-1:0] rx_base_lo,
  output logic [1:0]          start_err,
  output logic [1:0]          stop_noop,
  output logic                restore_err,
  output logic                fis_valid,
  input  logic                fis_ready,
  output logic [39:0]         fis_data,
  output logic                d2h_irq
);
  logic [ADDR_W-1:0] base_a [N_ENG];
  logic [N_ENG-1:0]  addr_ok;
  logic [CMD_W-1:0]  cmd_q;
  logic [31:0]       sig_q;
  logic [31:0]       shadow_q;
  logic [7:0]        status_q;

  assign base_a[0] = {list_base_hi, list_base_lo};
  assign base_a[1] = {rx_base_hi, rx_base_lo};

  for (genvar i = 0; i < N_ENG; i++) begin : g_chk
    localparam int AB = (i == 0) ? LIST_ALIGN_BITS : RX_ALIGN_BITS;
    spe_addr_check #(.ADDR_W(ADDR_W), .ALIGN_BITS(AB)) u_chk (
      .base(base_a[i]),
      .ok  (addr_ok[i])
    );
  end

  spe_cmd_reg u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_we),
    .wr_data    (reg_wdata),
    .restore_en (restore_en),
    .restore_img(restore_img),
    .addr_ok    (addr_ok),
    .cmd_q      (cmd_q),
    .start_err  (start_err),
    .stop_noop  (stop_noop),
    .restore_err(restore_err)
  );

  spe_init_fis u_fis (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_reset (port_reset),
    .drive_is_cd(drive_is_cd),
    .rx_enable  (cmd_q[RXE_BIT]),
    .rx_running (cmd_q[RXR_BIT]),
    .fis_ready  (fis_ready),
    .fis_valid  (fis_valid),
    .fis_data   (fis_data),
    .sig_q      (sig_q),
    .status_q   (status_q),
    .shadow_q   (shadow_q),
    .d2h_irq    (d2h_irq)
  );

  always_comb begin
    case (rd_sel_e'(rd_sel))
      SEL_CMD:    rd_data = cmd_q;
      SEL_SIG:    rd_data = sig_q;
      SEL_STATUS: rd_data = {24'b0, status_q};
      default:    rd_data = shadow_q;
    endcase
  end

  a_r9_no_request_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && !restore_en && !reg_wdata[RXE_BIT]) |-> !fis_valid);

  a_r7_zero_base_fails: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !restore_en && reg_wdata[LST_BIT] && !cmd_q[LSR_BIT] &&
    ({list_base_hi, list_base_lo} == '0) |=> start_err[0]);
endmodule

// File: tb/sata_port_engine_ctl_test.sv
module sata_port_engine_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n, port_reset, drive_is_cd, reg_we, restore_en, fis_ready;
  logic [31:0] reg_wdata, restore_img, rd_data;
  logic [1:0]  rd_sel, start_err, stop_noop;
  logic [31:0] list_base_hi, list_base_lo, rx_base_hi, rx_base_lo;
  logic        restore_err, fis_valid, d2h_irq;
  logic [39:0] fis_data;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [63:0] LB_OK  = 64'h0000_0001_0000_0400;
  localparam logic [63:0] LB_BAD = 64'h0000_0001_0000_0200;
  localparam logic [63:0] RB_OK  = 64'h0000_0002_0000_0100;
  localparam logic [63:0] RB_BAD = 64'h0000_0002_0000_0180;

  typedef struct packed {
    logic [31:0] wdata;
    logic [63:0] lb;
    logic [63:0] rb;
    logic [31:0] cmd;
    logic [1:0]  err;
    logic [1:0]  noop;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0001, LB_OK,  RB_OK,  32'h0000_8001, 2'b00, 2'b10},
    '{32'hF000_0011, LB_OK,  RB_OK,  32'h0000_C011, 2'b00, 2'b00},
    '{32'h0000_4010, LB_OK,  RB_OK,  32'h0000_4010, 2'b00, 2'b00},
    '{32'h0000_0000, LB_OK,  RB_OK,  32'h0000_0000, 2'b00, 2'b01},
    '{32'h0000_0000, LB_OK,  RB_OK,  32'h0000_0000, 2'b00, 2'b11},
    '{32'h0000_0001, LB_BAD, RB_OK,  32'h0000_0000, 2'b01, 2'b10},
    '{32'h0000_0011, 64'h0,  RB_BAD, 32'h0000_0000, 2'b11, 2'b00},
    '{32'h0ABC_0011, LB_OK,  RB_OK,  32'h0ABC_C011, 2'b00, 2'b00},
    '{32'h0000_0011, LB_OK,  RB_OK,  32'h0000_C011, 2'b00, 2'b00},
    '{32'h0000_0000, LB_OK,  RB_OK,  32'h0000_0000, 2'b00, 2'b00}
  };

  sata_port_engine_ctl uut (
    .clk(clk), .rst_n(rst_n), .port_reset(port_reset), .drive_is_cd(drive_is_cd),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .restore_en(restore_en), .restore_img(restore_img),
    .list_base_hi(list_base_hi), .list_base_lo(list_base_lo),
    .rx_base_hi(rx_base_hi), .rx_base_lo(rx_base_lo),
    .start_err(start_err), .stop_noop(stop_noop), .restore_err(restore_err),
    .fis_valid(fis_valid), .fis_ready(fis_ready), .fis_data(fis_data), .d2h_irq(d2h_irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic set_bases(input logic [63:0] lb, input logic [63:0] rb);
    {list_base_hi, list_base_lo} = lb;
    {rx_base_hi, rx_base_lo} = rb;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic restore(input logic [31:0] img);
    @(negedge clk);
    restore_en = 1'b1;
    restore_img = img;
    @(negedge clk);
    restore_en = 1'b0;
  endtask

  task automatic do_port_reset(input logic cd);
    @(negedge clk);
    drive_is_cd = cd;
    port_reset = 1'b1;
    @(negedge clk);
    port_reset = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; port_reset = 1'b0; drive_is_cd = 1'b0; reg_we = 1'b0;
    reg_wdata = '0; restore_en = 1'b0; restore_img = '0; fis_ready = 1'b0;
    rd_sel = 2'd0;
    set_bases(LB_OK, RB_OK);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, v); chk("R14 reset cmd", v, 32'h0);
    rd(2'd1, v); chk("R14 reset sig", v, 32'h0);
    rd(2'd2, v); chk("R11 reset disk status", v, 32'h30);
    rd(2'd3, v); chk("R11 reset disk shadow", v, 32'h0000_0101);
    chk("R9 reset no request", fis_valid, 1'b0);
    chk("R11 reset irq", d2h_irq, 1'b0);

    for (int i = 0; i < NV; i++) begin
      set_bases(VEC[i].lb, VEC[i].rb);
      wr(VEC[i].wdata);
      rd(2'd0, v);
      chk($sformatf("R1 R2 R3 R4 R5 R7 vec %0d cmd", i), v, VEC[i].cmd);
      chk($sformatf("R3 R5 vec %0d start_err", i), start_err, VEC[i].err);
      chk($sformatf("R6 vec %0d stop_noop", i), stop_noop, VEC[i].noop);
    end

    do_port_reset(1'b1);
    rd(2'd2, v); chk("R11 cd status", v, 32'h70);
    rd(2'd3, v); chk("R11 cd shadow", v, 32'hEB14_0101);

    set_bases(LB_OK, RB_OK);
    wr(32'h10);
    chk("R8 request raised", fis_valid, 1'b1);
    chk("R8 request payload", fis_data, {8'h70, 32'hEB14_0101});
    repeat (3) @(negedge clk);
    chk("R8 request held without ready", fis_valid, 1'b1);
    chk("R8 not sent without handshake", d2h_irq, 1'b0);

    wr(32'h0);
    chk("R9 request withdrawn", fis_valid, 1'b0);
    chk("R9 no irq on withdraw", d2h_irq, 1'b0);
    rd(2'd1, v); chk("R9 sig untouched", v, 32'h0);

    wr(32'h10);
    chk("R8 request again", fis_valid, 1'b1);
    @(negedge clk); fis_ready = 1'b1;
    @(negedge clk); fis_ready = 1'b0;
    chk("R10 request cleared after accept", fis_valid, 1'b0);
    chk("R10 irq set", d2h_irq, 1'b1);
    rd(2'd1, v); chk("R10 signature", v, 32'hEB14_0101);

    wr(32'h0);
    wr(32'h10);
    chk("R10 sent only once", fis_valid, 1'b0);

    do_port_reset(1'b0);
    rd(2'd3, v); chk("R11 disk shadow after port reset", v, 32'h0000_0101);
    rd(2'd2, v); chk("R11 disk status after port reset", v, 32'h30);
    chk("R11 irq cleared", d2h_irq, 1'b0);
    chk("R8 request rearmed", fis_valid, 1'b1);
    chk("R8 rearmed payload", fis_data, {8'h30, 32'h0000_0101});

    rd(2'd0, v); chk("R5 cmd before restore", v, 32'h0000_4010);
    restore(32'h0000_8000);
    chk("R12 list run without start", restore_err, 1'b1);
    rd(2'd0, v); chk("R12 cmd unchanged", v, 32'h0000_4010);
    restore(32'h0000_4001);
    chk("R12 rx run without enable", restore_err, 1'b1);
    rd(2'd0, v); chk("R12 cmd unchanged again", v, 32'h0000_4010);

    restore(32'hF000_C011);
    chk("R13 good restore no error", restore_err, 1'b0);
    chk("R13 good restore no start_err", start_err, 2'b00);
    rd(2'd0, v); chk("R13 restore restarts both", v, 32'h0000_C011);

    set_bases(LB_BAD, RB_OK);
    restore(32'h0000_C011);
    chk("R13 restore bad list base err", start_err, 2'b01);
    rd(2'd0, v); chk("R13 restore bad list base cmd", v, 32'h0000_4010);

    restore(32'h0);
    chk("R13 restore zero no error", restore_err, 1'b0);
    rd(2'd0, v); chk("R13 restore zero stops", v, 32'h0);

    set_bases(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0300);
    wr(32'h1);
    rd(2'd0, v); chk("R7 high-half list base valid", v, 32'h0000_8001);
    wr(32'h0);
    wr(32'h10);
    rd(2'd0, v); chk("R7 256-byte rx base valid", v, 32'h0000_4010);
    chk("R7 no error on valid rx base", start_err, 2'b00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule